// File: doc/BRIEF.md
# Boundary Write-Protect Controller

This block decides whether a write into a word-addressed memory array may go ahead. It keeps one boundary address. Every word at or above that address is shielded from writes. A serial front end decodes each command and hands it to the block, together with the address field and three levels: the protect-select pin, the program-enable pin and the current write-enable state. For a single-word write or a whole-array write, the block answers with a permit or a refusal. For a boundary read, it returns the stored boundary with a leading zero bit, ready to be shifted out.

The boundary can only be changed through a guarded sequence. An arming command must come directly before any change. The boundary can be changed by writing it once after a clear. A one-time lock freezes it for good. A clear and a boundary write of all ones leave the same value in the register, but they differ in effect. After a clear, the top word is writable and whole-array writes are permitted. After a boundary write of all ones, the top word is shielded and whole-array writes are refused. A separate cleared flag holds this difference.

Top module: `wprot_guard`

## Requirements
- R1: A single-word write is permitted while the cleared flag is set. Otherwise it is permitted only when its address is strictly below the stored boundary.
- R2: A protect command (arm, clear, set, lock or boundary read) given while protect-select is low has no effect on the boundary, the flags or the read output. It does disarm the block.
- R3: An arm command arms the block only when write-enable, protect-select and program-enable are all high. The arm state is cleared by any other command.
- R4: Clear, set and lock take effect only if the command directly before them was an accepted arm command. Idle cycles between the two commands do not break the pairing.
- R5: After reset, the boundary is all ones, the cleared flag is set and the block is unlocked. A clear restores this state, so the top word stays writable.
- R6: A boundary set to all ones shields the top word and refuses whole-array writes.
- R7: A boundary set is accepted only while the cleared flag is set. An accepted set stores the address field and drops the cleared flag.
- R8: A lock command sets a permanent lock. Once locked, no command ever changes the boundary or the cleared flag again.
- R9: A boundary read with protect-select high gives rd_bits_o = {1'b0, boundary}, with rd_valid_o high.
- R10: A whole-array write is permitted only while the cleared flag is set.
- R11: Any write is refused unless both write-enable and program-enable are high when it is issued.
- R12: Results appear on the outputs on the clock edge after the command is sampled. The op codes are: 0 single write, 1 whole-array write, 2 boundary read, 3 arm, 4 clear, 5 set, 6 lock, and 7 any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_v_i | input | 1 | A decoded command is present this cycle |
| cmd_op_i | input | 3 | Op code (see R12) |
| cmd_addr_i | input | ADDR_W | Address field of the command |
| psel_i | input | 1 | Protect-select pin level |
| pgm_i | input | 1 | Program-enable pin level |
| wen_i | input | 1 | Write-enable state from the front end |
| wr_done_o | output | 1 | A write decision is presented |
| wr_ok_o | output | 1 | The write is permitted |
| rd_valid_o | output | 1 | rd_bits_o holds a boundary read |
| rd_bits_o | output | ADDR_W+1 | Leading zero bit followed by the boundary |

## Verification
On every cycle, the assertions check the following:
- the lock never falls once it has been set;
- the boundary holds still unless an armed change was fired, and holds still once locked;
- a set without the cleared flag changes nothing;
- whole-array writes without the cleared flag, and writes lacking enable levels, are refused;
- the read word matches the boundary;
- the arm state rises only after a qualified arm command.

Only the bench scenarios can show the remaining properties. These are the different meanings of a clear and of an all-ones set at the top word, the pairing that breaks when another command comes between arm and change, and the permanence of the lock over a long command sequence.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [2:0] {
    OP_WRITE = 3'd0,
    OP_WALL  = 3'd1,
    OP_PREAD = 3'd2,
    OP_PARM  = 3'd3,
    OP_PCLR  = 3'd4,
    OP_PSET  = 3'd5,
    OP_PLOCK = 3'd6,
    OP_OTHER = 3'd7
  } op_e;
endpackage

// File: rtl/wpg_seq.sv
module wpg_seq
  import wpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_v_i,
  input  op_e  op_i,
  input  logic psel_i,
  input  logic pgm_i,
  input  logic wen_i,
  output logic arm_q,
  output logic clr_go,
  output logic set_go,
  output logic lock_go
);
  logic levels_ok;
  logic fire_ok;

  assign levels_ok = psel_i && pgm_i;
  assign fire_ok   = cmd_v_i && arm_q && levels_ok;
  assign clr_go    = fire_ok && (op_i == OP_PCLR);
  assign set_go    = fire_ok && (op_i == OP_PSET);
  assign lock_go   = fire_ok && (op_i == OP_PLOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (cmd_v_i) begin
      arm_q <= (op_i == OP_PARM) && levels_ok && wen_i;
    end
  end

  // R3: arming only follows a fully qualified arm command
  assert_arm_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> $past(cmd_v_i && wen_i && psel_i && pgm_i));
endmodule

// File: rtl/wpg_store.sv
module wpg_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_go,
  input  logic              set_go,
  input  logic              lock_go,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] bound_q,
  output logic              clr_q,
  output logic              lock_q
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic do_clr;
  logic do_set;
  logic do_lock;

  assign do_clr  = clr_go && !lock_q;
  assign do_set  = set_go && !lock_q && clr_q;
  assign do_lock = lock_go && !lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound_q <= ALL_ONES;
      clr_q   <= 1'b1;
      lock_q  <= 1'b0;
    end else begin
      if (do_clr) begin
        bound_q <= ALL_ONES;
        clr_q   <= 1'b1;
      end else if (do_set) begin
        bound_q <= addr_i;
        clr_q   <= 1'b0;
      end
      if (do_lock) lock_q <= 1'b1;
    end
  end

  // R8: lock is permanent and freezes the boundary
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_lock_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(bound_q) && $stable(clr_q)));
  // R4: no change without a fired armed command
  assert_no_unarmed_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_go || set_go) |=> ($stable(bound_q) && $stable(clr_q)));
  // R7: set without the cleared flag leaves the boundary alone
  assert_set_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_go && !clr_go && !clr_q) |=> $stable(bound_q));
endmodule

// File: rtl/wpg_judge.sv
module wpg_judge
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_v_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              psel_i,
  input  logic              pgm_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] bound_i,
  input  logic              clr_i,
  output logic              wr_done_o,
  output logic              wr_ok_o,
  output logic              rd_valid_o,
  output logic [ADDR_W:0]   rd_bits_o
);
  function automatic logic word_open(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic cleared);
    return cleared || (a < b);
  endfunction

  logic is_wr;
  logic is_wall;
  logic lvl_ok;
  logic permit;

  assign is_wr   = cmd_v_i && (op_i == OP_WRITE);
  assign is_wall = cmd_v_i && (op_i == OP_WALL);
  assign lvl_ok  = wen_i && pgm_i;
  assign permit  = lvl_ok && ((is_wr && word_open(addr_i, bound_i, clr_i)) ||
                              (is_wall && clr_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_done_o  <= 1'b0;
      wr_ok_o    <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_bits_o  <= '0;
    end else begin
      wr_done_o  <= is_wr || is_wall;
      wr_ok_o    <= permit;
      rd_valid_o <= cmd_v_i && (op_i == OP_PREAD) && psel_i;
      if (cmd_v_i && (op_i == OP_PREAD) && psel_i) rd_bits_o <= {1'b0, bound_i};
    end
  end

  // R10: whole-array write refused unless cleared
  assert_wall_needs_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wall && !clr_i) |=> (wr_done_o && !wr_ok_o));
  // R11: writes need both enable levels
  assert_levels_needed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_wr || is_wall) && !lvl_ok) |=> !wr_ok_o);
  // R9: read word carries a zero lead bit and the live boundary
  assert_read_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_bits_o == {1'b0, bound_i}));
  // R1: a permitted single write below a set boundary
  assert_write_below_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && lvl_ok && !clr_i && (addr_i >= bound_i)) |=> !wr_ok_o);
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_v_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              psel_i,
  input  logic              pgm_i,
  input  logic              wen_i,
  output logic              wr_done_o,
  output logic              wr_ok_o,
  output logic              rd_valid_o,
  output logic [ADDR_W:0]   rd_bits_o
);
  op_e               op;
  logic              arm_q;
  logic              clr_go;
  logic              set_go;
  logic              lock_go;
  logic [ADDR_W-1:0] bound_q;
  logic              clr_q;
  logic              lock_q;

  assign op = op_e'(cmd_op_i);

  wpg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_v_i(cmd_v_i), .op_i(op),
    .psel_i(psel_i), .pgm_i(pgm_i), .wen_i(wen_i),
    .arm_q(arm_q), .clr_go(clr_go), .set_go(set_go), .lock_go(lock_go)
  );

  wpg_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_go(clr_go), .set_go(set_go),
    .lock_go(lock_go), .addr_i(cmd_addr_i),
    .bound_q(bound_q), .clr_q(clr_q), .lock_q(lock_q)
  );

  wpg_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .cmd_v_i(cmd_v_i), .op_i(op),
    .addr_i(cmd_addr_i), .psel_i(psel_i), .pgm_i(pgm_i), .wen_i(wen_i),
    .bound_i(bound_q), .clr_i(clr_q),
    .wr_done_o(wr_done_o), .wr_ok_o(wr_ok_o),
    .rd_valid_o(rd_valid_o), .rd_bits_o(rd_bits_o)
  );

  // R2: protect commands with select low fire nothing
  assert_select_low_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v_i && !psel_i) |-> !(clr_go || set_go || lock_go));
  // R8: once locked, a clear fired later changes nothing
  assert_locked_clear_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && clr_go) |=> (clr_q == $past(clr_q)));
endmodule

// File: tb/sim_wprot_guard.sv
module sim_wprot_guard;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int ONES = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_v = 1'b0;
  logic [2:0] op = 3'd7;
  logic [AW-1:0] addr = '0;
  logic psel = 1'b0, pgm = 1'b0, wen = 1'b0;
  logic wr_done, wr_ok, rd_valid;
  logic [AW:0] rd_bits;

  int total = 0, bad = 0;
  int m_bnd = ONES;
  bit m_clr = 1, m_lock = 0, m_arm = 0;

  always #(CLK_P/2) clk = ~clk;

  wprot_guard #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_v_i(cmd_v), .cmd_op_i(op), .cmd_addr_i(addr),
    .psel_i(psel), .pgm_i(pgm), .wen_i(wen),
    .wr_done_o(wr_done), .wr_ok_o(wr_ok), .rd_valid_o(rd_valid), .rd_bits_o(rd_bits)
  );

  task automatic issue(input int o, input int a, input bit s, input bit p,
                       input bit w, input string tag);
    bit e_done, e_ok, e_rv, prot;
    int e_rb;
    e_done = (o == 0) || (o == 1);
    e_ok = 0;
    if (o == 0) e_ok = w && p && (m_clr || (a < m_bnd));
    if (o == 1) e_ok = w && p && m_clr;
    e_rv = (o == 2) && s;
    e_rb = m_bnd;
    prot = s && p && m_arm && !m_lock;
    if (o == 4 && prot) begin m_bnd = ONES; m_clr = 1; end
    if (o == 5 && prot && m_clr) begin m_bnd = a; m_clr = 0; end
    if (o == 6 && prot) m_lock = 1;
    m_arm = (o == 3) && s && p && w;
    @(negedge clk);
    cmd_v = 1'b1; op = 3'(o); addr = AW'(a); psel = s; pgm = p; wen = w;
    @(posedge clk);
    #1;
    cmd_v = 1'b0;
    total++;
    if (wr_done !== e_done || wr_ok !== e_ok || rd_valid !== e_rv ||
        (e_rv && rd_bits !== (AW+1)'(e_rb))) begin
      bad++;
      $display("FAIL %s op=%0d addr=%0d: got done=%b ok=%b rv=%b rb=%0d exp done=%b ok=%b rv=%b rb=%0d",
               tag, o, a, wr_done, wr_ok, rd_valid, rd_bits, e_done, e_ok, e_rv, e_rb);
    end
  endtask

  task automatic arm_it();
    issue(3, 0, 1, 1, 1, "R3");
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (wr_done !== 0 || wr_ok !== 0 || rd_valid !== 0) begin
      bad++;
      $display("FAIL R5 reset outputs got %b%b%b exp 000", wr_done, wr_ok, rd_valid);
    end
    issue(2, 0, 1, 0, 0, "R9");          // reset boundary all ones (R5)
    issue(0, ONES, 1, 1, 1, "R5");       // top word writable while cleared
    issue(1, 0, 0, 1, 1, "R10");         // whole-array ok when cleared
    issue(0, 3, 0, 0, 1, "R11");         // program-enable low
    issue(0, 3, 0, 1, 0, "R11");         // write-enable low
    issue(5, 8'h40, 1, 1, 1, "R4");      // set without arm ignored
    issue(2, 0, 1, 0, 0, "R4");
    issue(3, 0, 1, 1, 0, "R3");          // arm with wen low rejected
    issue(5, 8'h40, 1, 1, 1, "R3");
    issue(2, 0, 1, 0, 0, "R3");
    arm_it();
    repeat (4) @(negedge clk);           // idle cycles keep pairing
    issue(5, 8'h40, 1, 1, 1, "R7");
    issue(2, 0, 1, 0, 0, "R9");
    issue(0, 8'h3F, 0, 1, 1, "R1");
    issue(0, 8'h40, 0, 1, 1, "R1");
    issue(0, 8'h80, 0, 1, 1, "R1");
    issue(1, 0, 0, 1, 1, "R10");
    arm_it();
    issue(5, 8'h20, 1, 1, 1, "R7");      // not cleared: rejected
    issue(2, 0, 1, 0, 0, "R7");
    arm_it();
    issue(4, 0, 1, 1, 1, "R5");
    issue(2, 0, 1, 0, 0, "R5");
    issue(0, ONES, 0, 1, 1, "R5");
    arm_it();
    issue(5, ONES, 1, 1, 1, "R6");
    issue(0, ONES, 0, 1, 1, "R6");
    issue(0, ONES - 1, 0, 1, 1, "R6");
    issue(1, 0, 0, 1, 1, "R6");
    arm_it();
    issue(4, 0, 0, 1, 1, "R2");          // clear with select low ignored
    issue(2, 0, 1, 0, 0, "R2");
    issue(0, ONES, 0, 1, 1, "R2");
    issue(2, 0, 0, 0, 0, "R2");          // read with select low: no output
    arm_it();
    issue(7, 0, 0, 1, 1, "R4");          // other command breaks pairing
    issue(4, 0, 1, 1, 1, "R4");
    issue(2, 0, 1, 0, 0, "R4");
    arm_it();
    issue(4, 0, 1, 1, 1, "R8");
    arm_it();
    issue(5, 8'h10, 1, 1, 1, "R8");
    arm_it();
    issue(6, 0, 1, 1, 1, "R8");
    arm_it();
    issue(4, 0, 1, 1, 1, "R8");
    arm_it();
    issue(5, 8'h05, 1, 1, 1, "R8");
    issue(2, 0, 1, 0, 0, "R8");
    issue(0, 8'h0F, 0, 1, 1, "R12");
    issue(0, 8'h10, 0, 1, 1, "R12");
    issue(1, 0, 0, 1, 1, "R10");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule